// File: doc/BRIEF.md
# Configurable Quadrature Event Counter

This block keeps a 16-bit position count driven by two phase inputs (A and B), a trigger input and a single-cycle event strobe. Each of the three pin inputs is synchronized and then passes through an optional noise filter. The filter takes its samples on a tick from a shared prescaler, at the clock rate divided by 1, 4, 16 or 64. Counting is not a fixed x1/x2/x4 decode. Each edge-and-level combination has its own enable bit for counting up and its own enable bit for counting down, so the decode pattern is set entirely by the two enable vectors.

In any cycle the count either loads a new value, steps up by one, steps down by one, or holds. An up step from the period value or above wraps to zero and emits an overflow pulse. A down step from zero wraps to the period value and emits an underflow pulse.

The filter is a three-state machine per input. FS_STABLE moves to FS_PEND1 on a sample tick whose value differs from the accepted level. FS_PEND1 moves to FS_PEND2 on the next differing tick. FS_PEND2 accepts the new level and returns to FS_STABLE on a third differing tick. A tick whose sample equals the accepted level returns any state to FS_STABLE. The counter picks one of four actions each cycle: ACT_LOAD has the highest priority, then ACT_UP or ACT_DOWN, and ACT_HOLD covers no strobe or both strobes together.

Top module: `quad_event_counter`

## Requirements
- R1: While reset is asserted, count is 0 and both ovf_pulse and unf_pulse are 0.
- R2: inc_en selects the up conditions by bit. Bit 0 is a B rise with A low, bit 1 a B rise with A high, bit 2 a B fall with A low and bit 3 a B fall with A high. Bit 4 is an A rise with B low, bit 5 an A rise with B high, bit 6 an A fall with B low and bit 7 an A fall with B high. A qualifying level is the filtered level in the same cycle as the edge.
- R3: dec_en uses the same bit positions 0 to 7 to select the down conditions.
- R4: Bit 8 of inc_en or dec_en selects a trigger rising edge, and bit 9 selects a trigger falling edge.
- R5: Bit 10 selects ext_evt. The count steps once for every clock cycle in which ext_evt is high.
- R6: If an up condition and a down condition are both true in one cycle, the count is unchanged. When several up conditions are true at once, the count steps by only one.
- R7: When load_en is high, count takes load_val on the next clock edge, whatever the other inputs do.
- R8: An up step when count is at or above period sets count to 0 and raises ovf_pulse for exactly one cycle.
- R9: A down step when count is 0 sets count to period and raises unf_pulse for exactly one cycle.
- R10: When flt_en is set for an input and its divider code is 0, a new level is accepted only after three consecutive differing samples. A 2-cycle pulse is rejected. A held change reaches count 6 clock edges after the input changes.
- R11: Divider code 1 (bits [1:0] for A, [3:2] for B, [5:4] for the trigger) samples once every 4 clocks. A 5-cycle pulse is rejected and a held level is accepted.
- R12: When an input's filter is disabled, a change reaches count on the third clock edge, and a 1-cycle pulse is still counted.
- R13: An edge whose enable bit is clear, or whose level qualifier does not match, leaves count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Phase A pin |
| phase_b | input | 1 | Phase B pin |
| trig_in | input | 1 | Trigger pin |
| ext_evt | input | 1 | Synchronous event strobe |
| inc_en | input | 11 | Up-condition enables |
| dec_en | input | 11 | Down-condition enables |
| flt_en | input | 3 | Filter enables: bit 0 A, bit 1 B, bit 2 trigger |
| flt_div | input | 6 | Filter divider codes, 2 bits per input |
| period | input | 16 | Wrap limit |
| load_en | input | 1 | Load strobe |
| load_val | input | 16 | Value to load |
| count | output | 16 | Current count |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| unf_pulse | output | 1 | One-cycle underflow pulse |

## Verification
A filter state machine stuck in a pending state, or one that resets on the wrong sample, changes when an edge appears. This shows up at count as a step that arrives one or more edges early or late, or as a glitch that gets counted. The bench therefore checks count on the exact edge where the step should land. A wrong wrap or cancel decision shows at count on the very next edge, together with the flag pulse. A mis-decoded enable bit shows as a missing step or an extra step after a single edge of a known pattern.

// File: rtl/qec_pkg.sv
package qec_pkg;
    localparam int NUM_IN   = 3;
    localparam int IN_A     = 0;
    localparam int IN_B     = 1;
    localparam int IN_T     = 2;
    localparam int NUM_COND = 11;

    typedef enum logic [1:0] {FS_STABLE, FS_PEND1, FS_PEND2} flt_state_e;
    typedef enum logic [1:0] {ACT_HOLD, ACT_LOAD, ACT_UP, ACT_DOWN} cnt_act_e;

    typedef struct packed {
        logic lvl;
        logic prev;
    } sig_info_t;
endpackage

// File: rtl/qec_prescale.sv
module qec_prescale #(
    parameter int STAGES   = 4,
    parameter int STEP_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] ticks
);
    localparam int PW = STEP_LOG * (STAGES - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_tick
            if (k == 0) begin : g_full
                assign ticks[k] = 1'b1;
            end else begin : g_div
                assign ticks[k] = (div_q[STEP_LOG*k-1:0] == '0);
            end
        end
    endgenerate
endmodule

// File: rtl/qec_filter.sv
module qec_filter
    import qec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      din,
    input  logic      tick,
    input  logic      flt_on,
    output sig_info_t info
);
    logic       s1_q, s2_q, acc_q, acc_d, prev_q, lvl;
    flt_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FS_STABLE;
            acc_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            acc_q <= acc_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        acc_d = acc_q;
        if (tick) begin
            if (s2_q == acc_q) begin
                st_d = FS_STABLE;
            end else begin
                unique case (st_q)
                    FS_STABLE: st_d = FS_PEND1;
                    FS_PEND1:  st_d = FS_PEND2;
                    FS_PEND2: begin
                        st_d  = FS_STABLE;
                        acc_d = s2_q;
                    end
                    default:   st_d = FS_STABLE;
                endcase
            end
        end
    end

    assign lvl = flt_on ? acc_q : s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign info.lvl  = lvl;
    assign info.prev = prev_q;

    // R10: the accepted level only changes out of the last pending state
    assert_accept_after_three_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_q) |-> ($past(st_q) == FS_PEND2));
endmodule

// File: rtl/qec_cond.sv
module qec_cond
    import qec_pkg::*;
(
    input  sig_info_t             a,
    input  sig_info_t             b,
    input  sig_info_t             t,
    input  logic                  evt,
    input  logic [NUM_COND-1:0]   inc_en,
    input  logic [NUM_COND-1:0]   dec_en,
    output logic                  inc_stb,
    output logic                  dec_stb
);
    logic                a_r, a_f, b_r, b_f, t_r, t_f;
    logic [NUM_COND-1:0] hit;

    always_comb begin
        a_r = a.lvl & ~a.prev;
        a_f = ~a.lvl & a.prev;
        b_r = b.lvl & ~b.prev;
        b_f = ~b.lvl & b.prev;
        t_r = t.lvl & ~t.prev;
        t_f = ~t.lvl & t.prev;
        hit[0]  = b_r & ~a.lvl;
        hit[1]  = b_r &  a.lvl;
        hit[2]  = b_f & ~a.lvl;
        hit[3]  = b_f &  a.lvl;
        hit[4]  = a_r & ~b.lvl;
        hit[5]  = a_r &  b.lvl;
        hit[6]  = a_f & ~b.lvl;
        hit[7]  = a_f &  b.lvl;
        hit[8]  = t_r;
        hit[9]  = t_f;
        hit[10] = evt;
        inc_stb = |(hit & inc_en);
        dec_stb = |(hit & dec_en);
    end
endmodule

// File: rtl/qec_count.sv
module qec_count
    import qec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_stb,
    input  logic         dec_stb,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         ovf_pulse,
    output logic         unf_pulse
);
    cnt_act_e     act;
    logic [W-1:0] cnt_q, cnt_d;
    logic         ovf_q, unf_q, ovf_d, unf_d;

    always_comb begin
        if (load_en)                 act = ACT_LOAD;
        else if (inc_stb && !dec_stb) act = ACT_UP;
        else if (dec_stb && !inc_stb) act = ACT_DOWN;
        else                         act = ACT_HOLD;
    end

    always_comb begin
        cnt_d = cnt_q;
        ovf_d = 1'b0;
        unf_d = 1'b0;
        unique case (act)
            ACT_LOAD: cnt_d = load_val;
            ACT_UP: begin
                if (cnt_q >= period) begin
                    cnt_d = '0;
                    ovf_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ACT_DOWN: begin
                if (cnt_q == '0) begin
                    cnt_d = period;
                    unf_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ovf_q <= ovf_d;
            unf_q <= unf_d;
        end
    end

    assign count     = cnt_q;
    assign ovf_pulse = ovf_q;
    assign unf_pulse = unf_q;

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt_q == $past(load_val)));
    assert_cancel_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_stb && dec_stb && !load_en) |=> $stable(cnt_q));
    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_stb && !dec_stb && !load_en && cnt_q >= period) |=> (cnt_q == '0 && ovf_q));
    assert_wrap_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stb && !inc_stb && !load_en && cnt_q == '0) |=> (cnt_q == $past(period) && unf_q));
endmodule

// File: rtl/quad_event_counter.sv
module quad_event_counter
    import qec_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int FLT_STAGES = 4,
    parameter int FLT_STEP   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   phase_a,
    input  logic                   phase_b,
    input  logic                   trig_in,
    input  logic                   ext_evt,
    input  logic [10:0]            inc_en,
    input  logic [10:0]            dec_en,
    input  logic [2:0]             flt_en,
    input  logic [5:0]             flt_div,
    input  logic [CNT_W-1:0]       period,
    input  logic                   load_en,
    input  logic [CNT_W-1:0]       load_val,
    output logic [CNT_W-1:0]       count,
    output logic                   ovf_pulse,
    output logic                   unf_pulse
);
    localparam int DIV_W = $clog2(FLT_STAGES);

    logic [FLT_STAGES-1:0] ticks;
    logic [NUM_IN-1:0]     din_vec;
    sig_info_t             info [NUM_IN];
    logic                  inc_stb, dec_stb;

    assign din_vec = {trig_in, phase_b, phase_a};

    qec_prescale #(.STAGES(FLT_STAGES), .STEP_LOG(FLT_STEP)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .ticks (ticks)
    );

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_flt
            qec_filter u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .din    (din_vec[i]),
                .tick   (ticks[flt_div[DIV_W*i +: DIV_W]]),
                .flt_on (flt_en[i]),
                .info   (info[i])
            );
        end
    endgenerate

    qec_cond u_cond (
        .a       (info[IN_A]),
        .b       (info[IN_B]),
        .t       (info[IN_T]),
        .evt     (ext_evt),
        .inc_en  (inc_en),
        .dec_en  (dec_en),
        .inc_stb (inc_stb),
        .dec_stb (dec_stb)
    );

    qec_count #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_stb   (inc_stb),
        .dec_stb   (dec_stb),
        .load_en   (load_en),
        .load_val  (load_val),
        .period    (period),
        .count     (count),
        .ovf_pulse (ovf_pulse),
        .unf_pulse (unf_pulse)
    );

    // R5: an enabled event with nothing opposing it must reach the counter as an up strobe
    assert_event_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_evt && inc_en[10] && dec_en == '0) |-> inc_stb);
endmodule

// File: tb/test_quad_event_counter.sv
module test_quad_event_counter;
    localparam int CLK_P = 10;
    localparam int NV    = 16;
    // {inc_en, dec_en, start {A,B}, end {A,B}, delta (2-bit signed)}
    localparam logic [27:0] VEC [NV] = '{
        {11'h001, 11'h000, 2'b00, 2'b01, 2'b01},
        {11'h002, 11'h000, 2'b10, 2'b11, 2'b01},
        {11'h004, 11'h000, 2'b01, 2'b00, 2'b01},
        {11'h008, 11'h000, 2'b11, 2'b10, 2'b01},
        {11'h010, 11'h000, 2'b00, 2'b10, 2'b01},
        {11'h020, 11'h000, 2'b01, 2'b11, 2'b01},
        {11'h040, 11'h000, 2'b10, 2'b00, 2'b01},
        {11'h080, 11'h000, 2'b11, 2'b01, 2'b01},
        {11'h001, 11'h000, 2'b10, 2'b11, 2'b00},
        {11'h000, 11'h001, 2'b00, 2'b01, 2'b11},
        {11'h000, 11'h080, 2'b11, 2'b01, 2'b11},
        {11'h000, 11'h020, 2'b01, 2'b11, 2'b11},
        {11'h001, 11'h001, 2'b00, 2'b01, 2'b00},
        {11'h002, 11'h020, 2'b00, 2'b11, 2'b00},
        {11'h0FF, 11'h000, 2'b00, 2'b01, 2'b01},
        {11'h00F, 11'h000, 2'b00, 2'b10, 2'b00}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        phase_a = 1'b0, phase_b = 1'b0, trig_in = 1'b0, ext_evt = 1'b0;
    logic [10:0] inc_en = '0, dec_en = '0;
    logic [2:0]  flt_en = '0;
    logic [5:0]  flt_div = '0;
    logic [15:0] period = 16'hFFFF, load_val = '0;
    logic        load_en = 1'b0;
    logic [15:0] count;
    logic        ovf_pulse, unf_pulse;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    quad_event_counter i_quad_event_counter (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .trig_in(trig_in), .ext_evt(ext_evt), .inc_en(inc_en), .dec_en(dec_en),
        .flt_en(flt_en), .flt_div(flt_div), .period(period), .load_en(load_en),
        .load_val(load_val), .count(count), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] v);
        load_en = 1'b1; load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic evt_pulse();
        ext_evt = 1'b1;
        @(negedge clk);
        ext_evt = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        chk("R1 count", count, 16'd0);
        chk("R1 ovf", {15'd0, ovf_pulse}, 16'd0);
        chk("R1 unf", {15'd0, unf_pulse}, 16'd0);
        rst_n = 1'b1;
        wait_n(2);

        // vector table: R2, R3, R6, R13
        for (int v = 0; v < NV; v++) begin
            inc_en = '0; dec_en = '0;
            phase_a = VEC[v][5]; phase_b = VEC[v][4];
            wait_n(6);
            do_load(16'd100);
            inc_en = VEC[v][27:17]; dec_en = VEC[v][16:6];
            phase_a = VEC[v][3]; phase_b = VEC[v][2];
            wait_n(6);
            chk($sformatf("R2/R3/R6/R13 vector %0d", v), count,
                16'(100 + int'($signed(VEC[v][1:0]))));
        end
        inc_en = '0; dec_en = '0; phase_a = 1'b0; phase_b = 1'b0;
        wait_n(6);

        // R4 trigger edges
        do_load(16'd50);
        inc_en = 11'h100;
        trig_in = 1'b1; wait_n(6);
        chk("R4 trig rise up", count, 16'd51);
        inc_en = '0; dec_en = 11'h200;
        trig_in = 1'b0; wait_n(6);
        chk("R4 trig fall down", count, 16'd50);
        dec_en = '0;

        // R5 event held three cycles
        do_load(16'd10);
        inc_en = 11'h400;
        ext_evt = 1'b1; wait_n(3); ext_evt = 1'b0;
        chk("R5 event steps", count, 16'd13);

        // R7 load beats event
        ext_evt = 1'b1; load_en = 1'b1; load_val = 16'd500;
        @(negedge clk);
        ext_evt = 1'b0; load_en = 1'b0;
        chk("R7 load priority", count, 16'd500);

        // R8 overflow
        period = 16'd5;
        do_load(16'd5);
        evt_pulse();
        chk("R8 wrap to zero", count, 16'd0);
        chk("R8 ovf pulse", {15'd0, ovf_pulse}, 16'd1);
        @(negedge clk);
        chk("R8 ovf one cycle", {15'd0, ovf_pulse}, 16'd0);
        do_load(16'd7);
        evt_pulse();
        chk("R8 above period", count, 16'd0);

        // R9 underflow
        inc_en = '0; dec_en = 11'h400;
        evt_pulse();
        chk("R9 wrap to period", count, 16'd5);
        chk("R9 unf pulse", {15'd0, unf_pulse}, 16'd1);
        @(negedge clk);
        chk("R9 unf one cycle", {15'd0, unf_pulse}, 16'd0);
        dec_en = '0; period = 16'hFFFF;

        // R12 unfiltered latency and single-cycle pulse
        do_load(16'd0);
        inc_en = 11'h010;
        phase_a = 1'b1;
        wait_n(2);
        chk("R12 not yet", count, 16'd0);
        wait_n(1);
        chk("R12 third edge", count, 16'd1);
        phase_a = 1'b0; wait_n(6);
        phase_a = 1'b1; @(negedge clk); phase_a = 1'b0;
        wait_n(6);
        chk("R12 short pulse counted", count, 16'd2);

        // R10 filter, divide by 1
        flt_en = 3'b001; flt_div = 6'd0;
        do_load(16'd0);
        phase_a = 1'b1; wait_n(2); phase_a = 1'b0;
        wait_n(8);
        chk("R10 glitch rejected", count, 16'd0);
        phase_a = 1'b1;
        wait_n(5);
        chk("R10 before accept", count, 16'd0);
        wait_n(1);
        chk("R10 accepted", count, 16'd1);
        phase_a = 1'b0; wait_n(8);

        // R11 filter, divide by 4
        flt_div = 6'b000001;
        do_load(16'd0);
        phase_a = 1'b1; wait_n(5); phase_a = 1'b0;
        wait_n(12);
        chk("R11 slow glitch rejected", count, 16'd0);
        phase_a = 1'b1; wait_n(20);
        chk("R11 held accepted", count, 16'd1);
        phase_a = 1'b0; wait_n(20);

        inc_en = '0; flt_en = '0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule